// File: doc/BRIEF.md
# Sequential Stage/Clock Hill-Climbing Power Tracker

This controller sets the stage count and clock-rate code of a switched-capacitor charge pump so that the pump delivers as much output power as it can. It runs a perturb-and-observe search in two fixed phases. Each trial runs the pump for a programmable number of cycles, and the peak output voltage measured during that trial is the figure of merit. The first phase starts at the largest stage count and the slowest clock. It lowers the stage count one step per trial while the peak keeps rising. The second phase then raises the clock code one step per trial, again only while the peak keeps rising.

Searching one variable at a time keeps the worst-case number of trials close to the sum of the two setting counts. A full scan of every stage/clock pair would cost their product. When a step makes the peak worse or leaves it the same, the controller puts the previous setting back before it moves on, so a losing setting is never left applied. After the second phase the controller raises a one-cycle completion pulse. It then holds the chosen codes until the next start request.

The peak detector and converter are outside the block. The controller ends each trial by lowering the run enable. It then waits for a measurement strobe that carries the peak code for that trial.

Top module: `mppt_seq_ctrl`

## Requirements
- R1: After reset the stage code equals STAGE_MAX, the clock code is 0, and run enable, completion pulse and locked flag are all 0.
- R2: A start request accepted while idle or locked loads stage code STAGE_MAX and clock code 0 and clears the locked flag. During every trial the run enable is high for exactly the programmed window length in cycles (a length of 0 acts as 1), and the codes do not change while it is high.
- R3: The measurement strobe is acted on only while the controller waits after a trial. A strobe at any other time changes neither codes nor flags.
- R4: The peak from the first trial after a start is the baseline. In the stage phase, each trial whose peak improves on the best so far lowers the stage code by exactly 1 for the next trial.
- R5: A peak counts as an improvement only if it is strictly greater, as an unsigned number, than the best peak so far. An equal peak is no improvement.
- R6: A stage-phase trial with no improvement raises the stage code back by 1. In the same decision the clock phase begins, with the clock code raised by 1.
- R7: In the clock phase, each improving trial raises the clock code by 1. The first trial with no improvement lowers the clock code back by 1 and locks.
- R8: An improvement at stage code STAGE_MIN ends the stage phase with no further stage trial. An improvement at clock code FREQ_MAX locks with no further trial. Neither code ever leaves its range or wraps around.
- R9: On locking, the completion pulse is high for exactly one cycle, in the same cycle that the locked flag rises. Locked flag and codes then hold until the next accepted start.
- R10: A start request made while a search is in progress is ignored. The search result and the number of trials stay the same.
- R11: The number of trials in a search equals 1 + (STAGE_MAX − s) + [s > STAGE_MIN] + f + [f < FREQ_MAX], where s and f are the final stage and clock codes. Here [x] is 1 if x is true and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a new search |
| win_len_i | input | WIN_W | Trial window length in clock cycles |
| meas_done_i | input | 1 | Strobe: peak code of the last trial is valid |
| peak_i | input | PEAK_W | Unsigned peak output-voltage code |
| stage_o | output | STAGE_W | Pump stage-count code |
| freq_o | output | FREQ_W | Pump clock-rate code |
| run_en_o | output | 1 | Pump run enable for the trial window |
| done_o | output | 1 | One-cycle pulse when the search locks |
| locked_o | output | 1 | Search finished; codes are held |

## Verification
Some properties are checked on every cycle. The codes stay inside their ranges. Outside a start, the stage code moves by at most one step. The codes do not change while the pump runs. The completion pulse lasts one cycle and coincides with the locked flag. A locked result holds until a start arrives. The search path itself can only be shown by the bench scenarios, which use landscapes whose optimum is known in advance. These cover the strict comparison on plateaus, restoring a setting after a losing step, stopping at each range limit, the trial count, and ignoring stray starts and strobes.

// File: rtl/mppt_pkg.sv
package mppt_pkg;
    // Controller sequencing states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WAIT = 2'd2,
        ST_LOCK = 2'd3
    } ctrl_state_e;

    // Which variable is being climbed
    typedef enum logic {
        PH_STAGE = 1'b0,
        PH_FREQ  = 1'b1
    } search_phase_e;
endpackage

// File: rtl/mppt_window_timer.sv
// Counts one trial window; active for exactly the loaded length (0 acts as 1).
module mppt_window_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [WIN_W-1:0] len_i,
    output logic             active_o,
    output logic             expire_o
);
    localparam logic [WIN_W-1:0] ONE = WIN_W'(1);

    logic [WIN_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = (len_i == '0) ? ONE : len_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);
    assign expire_o = (cnt_q == ONE);
endmodule

// File: rtl/mppt_peak_judge.sv
// Keeps the best peak seen so far and flags a strictly greater new sample.
module mppt_peak_judge #(
    parameter int PEAK_W = 10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              capture_i,
    input  logic [PEAK_W-1:0] peak_i,
    output logic              better_o
);
    logic [PEAK_W-1:0] best_d, best_q;

    always_comb begin
        best_d = capture_i ? peak_i : best_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) best_q <= '0;
        else         best_q <= best_d;
    end

    assign better_o = (peak_i > best_q);
endmodule

// File: rtl/mppt_seq_ctrl.sv
module mppt_seq_ctrl #(
    parameter int STAGE_MIN = 1,
    parameter int STAGE_MAX = 16,
    parameter int FREQ_MAX  = 7,
    parameter int PEAK_W    = 10,
    parameter int WIN_W     = 16,
    parameter int STAGE_W   = $clog2(STAGE_MAX + 1),
    parameter int FREQ_W    = (FREQ_MAX > 0) ? $clog2(FREQ_MAX + 1) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [WIN_W-1:0]   win_len_i,
    input  logic               meas_done_i,
    input  logic [PEAK_W-1:0]  peak_i,
    output logic [STAGE_W-1:0] stage_o,
    output logic [FREQ_W-1:0]  freq_o,
    output logic               run_en_o,
    output logic               done_o,
    output logic               locked_o
);
    import mppt_pkg::*;

    localparam logic [STAGE_W-1:0] STG_LO  = STAGE_W'(STAGE_MIN);
    localparam logic [STAGE_W-1:0] STG_HI  = STAGE_W'(STAGE_MAX);
    localparam logic [STAGE_W-1:0] STG_ONE = STAGE_W'(1);
    localparam logic [FREQ_W-1:0]  FRQ_HI  = FREQ_W'(FREQ_MAX);
    localparam logic [FREQ_W-1:0]  FRQ_ONE = FREQ_W'(1);

    typedef struct packed {
        ctrl_state_e        state;
        search_phase_e      phase;
        logic               first;
        logic               done;
        logic [STAGE_W-1:0] stage;
        logic [FREQ_W-1:0]  freq;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic win_load;
    logic capture;
    logic better;
    logic win_active;
    logic win_expire;

    mppt_window_timer #(
        .WIN_W (WIN_W)
    ) i_timer (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .load_i   (win_load),
        .len_i    (win_len_i),
        .active_o (win_active),
        .expire_o (win_expire)
    );

    mppt_peak_judge #(
        .PEAK_W (PEAK_W)
    ) i_judge (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (capture),
        .peak_i    (peak_i),
        .better_o  (better)
    );

    logic stage_room;
    logic freq_room;
    assign stage_room = (cur_q.stage > STG_LO);
    assign freq_room  = (cur_q.freq < FRQ_HI);

    always_comb begin
        logic take;
        logic to_freq;
        logic to_lock;
        logic go_run;

        nxt_d    = cur_q;
        nxt_d.done = 1'b0;
        win_load = 1'b0;
        capture  = 1'b0;
        take     = 1'b0;
        to_freq  = 1'b0;
        to_lock  = 1'b0;
        go_run   = 1'b0;

        unique case (cur_q.state)
            ST_IDLE, ST_LOCK: begin
                if (start_i) begin
                    nxt_d.stage = STG_HI;
                    nxt_d.freq  = '0;
                    nxt_d.phase = PH_STAGE;
                    nxt_d.first = 1'b1;
                    go_run      = 1'b1;
                end
            end
            ST_RUN: begin
                if (win_expire) nxt_d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (meas_done_i) begin
                    take        = cur_q.first || better;
                    capture     = take;
                    nxt_d.first = 1'b0;
                    if (cur_q.phase == PH_STAGE) begin
                        if (take && stage_room) begin
                            nxt_d.stage = cur_q.stage - STG_ONE;
                            go_run      = 1'b1;
                        end else begin
                            if (!take) nxt_d.stage = cur_q.stage + STG_ONE;
                            to_freq = 1'b1;
                        end
                    end else begin
                        if (take && freq_room) begin
                            nxt_d.freq = cur_q.freq + FRQ_ONE;
                            go_run     = 1'b1;
                        end else begin
                            if (!take) nxt_d.freq = cur_q.freq - FRQ_ONE;
                            to_lock = 1'b1;
                        end
                    end
                    if (to_freq) begin
                        nxt_d.phase = PH_FREQ;
                        if (freq_room) begin
                            nxt_d.freq = cur_q.freq + FRQ_ONE;
                            go_run     = 1'b1;
                        end else begin
                            to_lock = 1'b1;
                        end
                    end
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase

        if (go_run) begin
            win_load    = 1'b1;
            nxt_d.state = ST_RUN;
        end
        if (to_lock) begin
            nxt_d.state = ST_LOCK;
            nxt_d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cur_q.state <= ST_IDLE;
            cur_q.phase <= PH_STAGE;
            cur_q.first <= 1'b0;
            cur_q.done  <= 1'b0;
            cur_q.stage <= STG_HI;
            cur_q.freq  <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign stage_o  = cur_q.stage;
    assign freq_o   = cur_q.freq;
    assign run_en_o = win_active;
    assign done_o   = cur_q.done;
    assign locked_o = (cur_q.state == ST_LOCK);
endmodule

// File: rtl/mppt_seq_ctrl_chk.sv
module mppt_seq_ctrl_chk #(
    parameter int STAGE_MIN = 1,
    parameter int STAGE_MAX = 16,
    parameter int FREQ_MAX  = 7,
    parameter int STAGE_W   = 5,
    parameter int FREQ_W    = 3
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               start_i,
    input logic [STAGE_W-1:0] stage_o,
    input logic [FREQ_W-1:0]  freq_o,
    input logic               run_en_o,
    input logic               done_o,
    input logic               locked_o
);
    AST_STAGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(stage_o) >= STAGE_MIN) && (int'(stage_o) <= STAGE_MAX)); // R8
    AST_FREQ_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(freq_o) <= FREQ_MAX); // R8
    AST_STAGE_UNIT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((stage_o != $past(stage_o)) && !$past(start_i)) |->
        ((int'(stage_o) == int'($past(stage_o)) + 1) || (int'(stage_o) == int'($past(stage_o)) - 1))); // R4
    AST_CODES_STILL_IN_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_en_o && $past(run_en_o)) |-> ($stable(stage_o) && $stable(freq_o))); // R2
    AST_NO_RUN_WHEN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_en_o |-> !locked_o); // R2
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9
    AST_DONE_WITH_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (locked_o && !$past(locked_o))); // R9
    AST_LOCK_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (locked_o && !start_i) |=> (locked_o && $stable(stage_o) && $stable(freq_o))); // R9
endmodule

bind mppt_seq_ctrl mppt_seq_ctrl_chk #(
    .STAGE_MIN (STAGE_MIN),
    .STAGE_MAX (STAGE_MAX),
    .FREQ_MAX  (FREQ_MAX),
    .STAGE_W   (STAGE_W),
    .FREQ_W    (FREQ_W)
) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .stage_o  (stage_o),
    .freq_o   (freq_o),
    .run_en_o (run_en_o),
    .done_o   (done_o),
    .locked_o (locked_o)
);

// File: tb/test_mppt_seq_ctrl.sv
module test_mppt_seq_ctrl;
    localparam int STAGE_MIN = 1;
    localparam int STAGE_MAX = 16;
    localparam int FREQ_MAX  = 7;
    localparam int PEAK_W    = 10;
    localparam int WIN_W     = 16;
    localparam int STAGE_W   = 5;
    localparam int FREQ_W    = 3;
    localparam int LAT       = 3;
    localparam int BASE      = 1000;
    localparam int NVEC      = 5;

    // n_opt, f_opt, k_stage, k_freq, window, inject, exp_stage, exp_freq, exp_trials
    localparam int VEC [NVEC][9] = '{
        '{ 5, 3, 20, 15, 5, 0,  5, 3, 17},
        '{16, 0, 10, 10, 3, 0, 16, 0,  3},
        '{ 1, 7,  8,  8, 1, 0,  1, 7, 23},
        '{ 9, 7,  0, 12, 4, 1, 16, 7,  9},
        '{ 3, 2,  6,  0, 2, 1,  3, 0, 16}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic [WIN_W-1:0]   win_len = WIN_W'(5);
    logic               meas_done = 1'b0;
    logic [PEAK_W-1:0]  peak = '0;
    logic [STAGE_W-1:0] stage;
    logic [FREQ_W-1:0]  freq;
    logic               run_en;
    logic               done;
    logic               locked;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    mppt_seq_ctrl #(
        .STAGE_MIN (STAGE_MIN), .STAGE_MAX (STAGE_MAX), .FREQ_MAX (FREQ_MAX),
        .PEAK_W (PEAK_W), .WIN_W (WIN_W)
    ) i_mppt_seq_ctrl (
        .clk_i (clk), .rst_ni (rst_n), .start_i (start), .win_len_i (win_len),
        .meas_done_i (meas_done), .peak_i (peak), .stage_o (stage), .freq_o (freq),
        .run_en_o (run_en), .done_o (done), .locked_o (locked)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int land(input int s, input int f, input int no, input int fo,
                                input int ks, input int kf);
        int ds = (s > no) ? s - no : no - s;
        int df = (f > fo) ? f - fo : fo - f;
        int v = BASE - ks * ds - kf * df;
        return (v < 0) ? 0 : v;
    endfunction

    // Runs one search against a synthetic landscape; starts at a negedge.
    task automatic run_search(input int vi, output int trials, output int bad_len);
        int run_cnt = 0;
        int guard = 0;
        bit got = 1'b0;
        trials  = 0;
        bad_len = 0;
        win_len = WIN_W'(VEC[vi][4]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!got && guard < 20000) begin
            guard++;
            start = 1'b0;
            meas_done = 1'b0;
            if (done) begin
                got = 1'b1;
            end else if (run_en) begin
                run_cnt++;
                if (VEC[vi][5] != 0 && trials == 2 && run_cnt == 1) begin
                    start = 1'b1;            // R10: stray start mid-search
                    meas_done = 1'b1;        // R3: stray strobe during a run
                    peak = PEAK_W'(1023);
                end
                @(negedge clk);
            end else if (run_cnt != 0) begin
                trials++;
                if (run_cnt != VEC[vi][4]) bad_len++;
                run_cnt = 0;
                repeat (LAT - 1) @(negedge clk);
                peak = PEAK_W'(land(int'(stage), int'(freq), VEC[vi][0], VEC[vi][1],
                                    VEC[vi][2], VEC[vi][3]));
                meas_done = 1'b1;
                @(negedge clk);
                meas_done = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    initial begin
        int trials;
        int bad_len;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 stage", int'(stage), STAGE_MAX);
        check("R1 freq", int'(freq), 0);
        check("R1 flags", int'({run_en, done, locked}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: strobe while idle is ignored
        meas_done = 1'b1; peak = PEAK_W'(500);
        @(negedge clk);
        meas_done = 1'b0;
        @(negedge clk);
        check("R3 idle strobe", int'({run_en, locked, stage, freq}), STAGE_MAX << FREQ_W);

        for (int v = 0; v < NVEC; v++) begin
            run_search(v, trials, bad_len);
            // R4 R5 R6 R7 R8: final codes from the known landscape
            check("R4/R6/R8 stage", int'(stage), VEC[v][6]);
            check("R5/R7/R8 freq", int'(freq), VEC[v][7]);
            check("R11 trials", trials, VEC[v][8]);  // R10 for injected vectors
            check("R2 run length", bad_len, 0);
            check("R9 locked with pulse", int'({done, locked}), 3);
            @(negedge clk);
            check("R9 pulse one cycle", int'({done, locked}), 1);
            meas_done = 1'b1; peak = PEAK_W'(1023);
            @(negedge clk);
            meas_done = 1'b0;
            repeat (4) @(negedge clk);
            check("R3 R9 hold after lock", int'({locked, stage, freq}),
                  (1 << (STAGE_W + FREQ_W)) | (VEC[v][6] << FREQ_W) | VEC[v][7]);
        end

        // R2: start from locked reloads codes and clears lock
        win_len = WIN_W'(6);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 restart codes", int'({locked, stage, freq}), STAGE_MAX << FREQ_W);
        check("R2 run starts", int'(run_en), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule